// File: doc/BRIEF.md
# Single-Cycle Unaligned Word Memory

This block is a word-wide RAM that accepts a 32-bit read or write at any byte address and completes it in one access. Storage is split into four 8-bit banks, one per byte lane. Each bank has its own word address. For an aligned access every bank gets the same word. For an unaligned access, the lanes below the byte offset move on to the following word. This means bytes that straddle two words are fetched or stored together, with no second cycle.

The requester uses a plain little-endian view. Byte j of the data bus always belongs to byte address `addr + j`. Write data is rotated into bank order before storage. Read data is rotated back out of bank order after the banks return it. Reads are synchronous, with one cycle of latency. The banks read before they write, so an access returns the contents the location held before that same access. One access is issued on every clock cycle, with no handshake.

Top module: `skew_word_ram`

## Requirements
- R1: While reset is high, `rd_data` is zero.
- R2: The cycle after an access at a byte address whose two low bits are 0, `rd_data[8j+7:8j]` holds the byte at address `byte_addr + j`, for j = 0..3.
- R3: The same byte mapping as R2 holds for byte offsets 1, 2 and 3, and each such access completes in a single cycle.
- R4: When `wr_en` is 1, `wr_data[8j+7:8j]` is stored at byte address `byte_addr + j` for j = 0..3. All other bytes are left unchanged.
- R5: Byte lane k (the byte lane holding byte addresses ≡ k mod 4) uses word address base+1 when k is less than the byte offset `byte_addr[1:0]`, and base otherwise. Here base is `byte_addr` with the two low bits removed.
- R6: Byte addresses wrap modulo the memory size (4 × 2^WORD_AW bytes). An access near the top continues at byte address 0.
- R7: An access that writes returns, one cycle later, the bytes the addressed locations held before that write.
- R8: Accesses may be issued on every consecutive cycle, mixing reads and writes, and each returns its own result one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_addr | input | WORD_AW+2 | Byte address of the access |
| wr_en | input | 1 | 1 = write this cycle |
| wr_data | input | 32 | Write data, byte j for address byte_addr+j |
| rd_data | output | 32 | Read data of the previous cycle's access |

## Verification
On every cycle, the assertions check how the word addresses are spread over the lanes. The number of lanes that take the following word equals the byte offset. Aligned accesses drive one common word, and unaligned ones split the lanes. A write followed by a read of the same bank word returns the written byte. The bench's byte-array model is the only check of the end-to-end byte order through both rotations. It also covers wrap at the top of memory, read-before-write results, and bytes left unchanged next to an overlapping unaligned store.

// File: rtl/skew_pkg.sv
package skew_pkg;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/skew_lane_addr.sv
module skew_lane_addr #(
  parameter int WORD_AW = 6,
  parameter int LANES   = 4,
  localparam int OFF_W  = $clog2(LANES)
) (
  input  logic [WORD_AW-1:0]            base,
  input  logic [OFF_W-1:0]              off,
  output logic [LANES-1:0][WORD_AW-1:0] lane_addr
);
  logic [WORD_AW-1:0] base_next;
  assign base_next = base + 1'b1;  // wraps modulo bank depth

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam logic [OFF_W-1:0] KI = OFF_W'(k);
    assign lane_addr[k] = (KI < off) ? base_next : base;
  end
endmodule

// File: rtl/skew_byte_bank.sv
module skew_byte_bank #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] rd
);
  localparam int DEPTH = 2 ** AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
  end

  // read-first output register, resettable
  always_ff @(posedge clk) begin
    if (rst) rd <= '0;
    else     rd <= mem[addr];
  end

  // R4
  bank_write_read_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(we) && !we && addr == $past(addr)) |=> rd == $past(wd, 2));
endmodule

// File: rtl/skew_byte_rotator.sv
module skew_byte_rotator #(
  parameter int LANES = 4,
  parameter int DW    = 8,
  parameter bit LEFT  = 1'b0,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [LANES*DW-1:0] din,
  input  logic [OFF_W-1:0]    amt,
  output logic [LANES*DW-1:0] dout
);
  for (genvar k = 0; k < LANES; k++) begin : g_rot
    localparam logic [OFF_W-1:0] KI = OFF_W'(k);
    logic [OFF_W-1:0] src;
    if (LEFT) begin : g_left
      assign src = KI - amt;
    end else begin : g_right
      assign src = KI + amt;
    end
    assign dout[k*DW +: DW] = din[src*DW +: DW];
  end
endmodule

// File: rtl/skew_word_ram.sv
module skew_word_ram
  import skew_pkg::*;
#(
  parameter int WORD_AW = 6,
  parameter int LANES   = 4,
  localparam int OFF_W  = $clog2(LANES),
  localparam int DATA_W = LANES * BYTE_W,
  localparam int BA_W   = WORD_AW + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BA_W-1:0]   byte_addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  logic [OFF_W-1:0]              off, rd_off;
  logic [WORD_AW-1:0]            base;
  logic [LANES-1:0][WORD_AW-1:0] lane_addr;
  logic [DATA_W-1:0]             wr_lanes, rd_lanes;

  assign off  = byte_addr[OFF_W-1:0];
  assign base = byte_addr[BA_W-1:OFF_W];

  skew_lane_addr #(.WORD_AW(WORD_AW), .LANES(LANES)) i_lane_addr (
    .base(base), .off(off), .lane_addr(lane_addr)
  );

  skew_byte_rotator #(.LANES(LANES), .DW(BYTE_W), .LEFT(1'b1)) i_wr_rot (
    .din(wr_data), .amt(off), .dout(wr_lanes)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_bank
    skew_byte_bank #(.AW(WORD_AW), .DW(BYTE_W)) i_bank (
      .clk(clk), .rst(rst), .we(wr_en), .addr(lane_addr[k]),
      .wd(wr_lanes[k*BYTE_W +: BYTE_W]), .rd(rd_lanes[k*BYTE_W +: BYTE_W])
    );
  end

  // offset follows the bank read latency
  always_ff @(posedge clk) begin
    if (rst) rd_off <= '0;
    else     rd_off <= off;
  end

  skew_byte_rotator #(.LANES(LANES), .DW(BYTE_W), .LEFT(1'b0)) i_rd_rot (
    .din(rd_lanes), .amt(rd_off), .dout(rd_data)
  );

  logic [LANES-1:0] uses_next;
  for (genvar k = 0; k < LANES; k++) begin : g_next
    assign uses_next[k] = (lane_addr[k] != base);
  end

  // R5
  lane_count_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(uses_next) == int'(off));

  // R2
  aligned_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    (off == '0) |-> (uses_next == '0));

  // R3
  split_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    (off != '0) |-> (lane_addr[0] != lane_addr[LANES-1]));
endmodule

// File: tb/test_skew_word_ram.sv
module test_skew_word_ram;
  localparam int WORD_AW = 6;
  localparam int NB = 4 * (2 ** WORD_AW);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [WORD_AW+1:0] byte_addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;

  always #5 clk = ~clk;

  skew_word_ram #(.WORD_AW(WORD_AW)) i_skew_word_ram (
    .clk(clk), .rst(rst), .byte_addr(byte_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data)
  );

  logic [7:0] mdl [NB];
  bit         known [NB];
  int  nvec = 0, nfail = 0;
  bit  pend = 0, pend_ok = 0, done = 0;
  logic [31:0] pend_exp;
  string pend_tag;

  task automatic check_pending();
    if (pend && pend_ok) begin
      nvec++;
      if (rd_data !== pend_exp) begin
        nfail++;
        $display("FAIL %s: rd_data=%h expected=%h", pend_tag, rd_data, pend_exp);
      end
    end
    pend = 0;
  endtask

  task automatic acc(input int a, input bit w, input logic [31:0] d, input string tag);
    int idx;
    @(negedge clk);
    check_pending();
    pend_ok = 1;
    for (int j = 0; j < 4; j++) begin
      idx = (a + j) % NB;
      pend_exp[8*j +: 8] = mdl[idx];
      if (!known[idx]) pend_ok = 0;
    end
    if (w) for (int j = 0; j < 4; j++) begin
      idx = (a + j) % NB;
      mdl[idx] = d[8*j +: 8];
      known[idx] = 1;
    end
    byte_addr = (WORD_AW+2)'(a % NB);
    wr_en = w;
    wr_data = d;
    pend = 1;
    pend_tag = tag;
  endtask

  task automatic flush();
    @(negedge clk);
    check_pending();
    wr_en = 0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    int a;
    // R1: output zero while in reset
    repeat (3) begin
      @(negedge clk);
      nvec++;
      if (rd_data !== 32'h0) begin
        nfail++;
        $display("FAIL R1: rd_data=%h expected=%h", rd_data, 32'h0);
      end
    end
    @(negedge clk);
    rst = 0;

    // R4: fill every word with an aligned write
    for (int w = 0; w < NB / 4; w++)
      acc(4 * w, 1, {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)} ^ 32'h5A00_00A5, "R4");
    // R2: aligned read-back of every word
    for (int w = 0; w < NB / 4; w++) acc(4 * w, 0, 32'h0, "R2");
    // R3: unaligned reads at each offset
    for (int i = 0; i < 24; i++) acc(4 * (i * 5 % 60) + 1 + (i % 3), 0, 32'h0, "R3");
    // R4/R5: unaligned writes, then aligned reads of both touched words
    for (int o = 1; o < 4; o++) begin
      a = 40 + 8 * o + o;
      acc(a, 1, 32'hC0DE_0000 + 32'(o), "R4");
      acc(a & ~3, 0, 32'h0, "R5");
      acc((a & ~3) + 4, 0, 32'h0, "R5");
      acc(a, 0, 32'h0, "R3");
    end
    // overlapping unaligned stores, neighbours must survive
    acc(101, 1, 32'h1122_3344, "R4");
    acc(103, 1, 32'hAABB_CCDD, "R4");
    acc(100, 0, 32'h0, "R4");
    acc(104, 0, 32'h0, "R4");
    acc(102, 0, 32'h0, "R4");
    // R6: wrap at top of memory
    acc(NB - 2, 1, 32'hFEED_BEEF, "R6");
    acc(NB - 2, 0, 32'h0, "R6");
    acc(NB - 4, 0, 32'h0, "R6");
    acc(0, 0, 32'h0, "R6");
    acc(NB - 1, 0, 32'h0, "R6");
    // R7: read-before-write results
    acc(9, 1, 32'h0BAD_F00D, "R7");
    acc(9, 1, 32'h1234_5678, "R7");
    acc(10, 1, 32'h9999_0000, "R7");
    acc(9, 0, 32'h0, "R7");
    // R8: back-to-back mixed traffic
    a = 17;
    for (int i = 0; i < 60; i++) begin
      a = (a * 13 + 7) % NB;
      acc(a, (i % 3) == 0, 32'hA5A5_0000 ^ 32'(i * 977), "R8");
    end
    flush();

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule